// File: doc/BRIEF.md
# Tagged Word Trap Detector

This block sits beside the execute stage of a processor that works on tagged words. Each word carries a data field, a type tag and a generation tag. Each memory word also carries a full/empty bit and an old/new bit. For every instruction it receives, the block checks both operands and, for memory accesses, the stored word's state bits. It reports at most one trap: the one with the highest priority. Each trap has its own vector code, so a handler never has to work out the cause again.

Accepted instructions appear on the outputs one clock later. When the instruction is clean, the block drives the write enables for the destination register and for the memory state bits. When any trap is reported, all write enables stay low, so a handler can re-issue the instruction unchanged.

The access kind is a 2-bit field: 0 is an ALU operation, 1 is a load, 2 is a store, and 3 is a software tag check. Type tags are parameters with these defaults: fixnum 0, future 1, pair (cons) 2, nil 3. For loads and stores, operand A is the base pointer. For a store, operand B is the value being written.

Top module: `tag_trap_detect`

## Requirements
- R1: While rst_n is low, out_valid, trap_valid, reg_we, fe_we, old_we, fe_val and old_val are 0 and trap_code is 0.
- R2: in_valid high gives out_valid high exactly one cycle later. A cycle with in_valid low gives out_valid, trap_valid, reg_we, fe_we and old_we all low in the next cycle. trap_code is 0 whenever trap_valid is low.
- R3: For an ALU operation with chk_future set, operand A of type future reports code 1. Otherwise, operand B of type future reports code 2.
- R4: For an ALU operation with chk_fixnum set, an operand whose type is neither fixnum nor future reports code 3. Codes 1 and 2 take precedence over code 3.
- R5: For a load or store with chk_cons set, the base fails when its type is not cons. When cons_nil_ok is set, nil is also accepted. A failed base reports code 4, which outranks every memory-state trap.
- R6: A software tag check (kind 3) reports code 5 when the zero-extended type tag of A differs from b_data. It has no enable.
- R7: For an ALU operation with chk_ovf set, a two's-complement overflow of a_data + b_data reports code 6.
- R8: For a store with chk_gen set, b_gen greater than a_gen reports code 7. An equal or smaller b_gen does not trap.
- R9: For a load with chk_transport set, word_old = 1 reports code 8.
- R10: For a load with chk_empty set, word_full = 0 reports code 9. Code 8 wins when both conditions hold.
- R11: A clean ALU operation sets reg_we. A clean load sets reg_we and fe_we, with fe_val equal to load_leave_full. A clean store sets old_we, with old_val equal to store_mark_old.
- R12: When trap_valid is high, reg_we, fe_we and old_we are all low.
- R13: A software tag check never raises a write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| op_kind | input | 2 | 0 ALU, 1 load, 2 store, 3 tag check |
| a_data | input | DATA_W | Operand A data field (base pointer for memory) |
| a_type | input | TYPE_W | Operand A type tag |
| a_gen | input | GEN_W | Operand A generation tag |
| b_data | input | DATA_W | Operand B data field |
| b_type | input | TYPE_W | Operand B type tag |
| b_gen | input | GEN_W | Operand B generation tag |
| chk_future | input | 1 | Enable future-operand trap |
| chk_fixnum | input | 1 | Enable non-fixnum trap |
| chk_ovf | input | 1 | Enable overflow trap |
| chk_cons | input | 1 | Enable base-type trap |
| cons_nil_ok | input | 1 | Accept nil as a base type |
| chk_gen | input | 1 | Enable generation-order trap |
| chk_transport | input | 1 | Enable old-word trap on loads |
| chk_empty | input | 1 | Enable empty-word trap on loads |
| load_leave_full | input | 1 | Full/empty value a load leaves behind |
| store_mark_old | input | 1 | Old/new value a store writes |
| word_full | input | 1 | Stored word's full bit |
| word_old | input | 1 | Stored word's old bit |
| out_valid | output | 1 | Result present |
| trap_valid | output | 1 | A trap is reported |
| trap_code | output | 4 | Vector code, 0 when no trap |
| reg_we | output | 1 | Register write-back enable |
| fe_we | output | 1 | Full/empty bit write enable |
| fe_val | output | 1 | Full/empty value to write |
| old_we | output | 1 | Old/new bit write enable |
| old_val | output | 1 | Old/new value to write |

## Verification
Several trap causes can be true in the same instruction. The stimulus creates these overlaps on purpose. It makes both operands futures, and pairs a future with a non-fixnum operand. It gives a store a bad base type and a generation inversion together. It gives a load a word that is both old and empty. In each case the scoreboard expects only the higher-priority code, with every write enable low. A later clean access of the same kind, with the conflicting condition removed or disabled, must then produce the write-back and the selected state value.

// File: rtl/tag_trap_detect.sv
module tag_trap_detect #(
  parameter int DATA_W    = 32,
  parameter int TYPE_W    = 5,
  parameter int GEN_W     = 3,
  parameter int TY_FIXNUM = 0,
  parameter int TY_FUTURE = 1,
  parameter int TY_CONS   = 2,
  parameter int TY_NIL    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] a_data,
  input  logic [TYPE_W-1:0] a_type,
  input  logic [GEN_W-1:0]  a_gen,
  input  logic [DATA_W-1:0] b_data,
  input  logic [TYPE_W-1:0] b_type,
  input  logic [GEN_W-1:0]  b_gen,
  input  logic              chk_future,
  input  logic              chk_fixnum,
  input  logic              chk_ovf,
  input  logic              chk_cons,
  input  logic              cons_nil_ok,
  input  logic              chk_gen,
  input  logic              chk_transport,
  input  logic              chk_empty,
  input  logic              load_leave_full,
  input  logic              store_mark_old,
  input  logic              word_full,
  input  logic              word_old,
  output logic              out_valid,
  output logic              trap_valid,
  output logic [3:0]        trap_code,
  output logic              reg_we,
  output logic              fe_we,
  output logic              fe_val,
  output logic              old_we,
  output logic              old_val
);
  localparam logic [TYPE_W-1:0] T_FIX = TYPE_W'(TY_FIXNUM);
  localparam logic [TYPE_W-1:0] T_FUT = TYPE_W'(TY_FUTURE);
  localparam logic [TYPE_W-1:0] T_CON = TYPE_W'(TY_CONS);
  localparam logic [TYPE_W-1:0] T_NIL = TYPE_W'(TY_NIL);

  wire is_alu   = op_kind == 2'd0;
  wire is_load  = op_kind == 2'd1;
  wire is_store = op_kind == 2'd2;
  wire is_tchk  = op_kind == 2'd3;
  wire is_mem   = is_load | is_store;

  wire fut_a = a_type == T_FUT;
  wire fut_b = b_type == T_FUT;
  wire odd_a = (a_type != T_FIX) && !fut_a;
  wire odd_b = (b_type != T_FIX) && !fut_b;
  wire base_ok = (a_type == T_CON) || (cons_nil_ok && a_type == T_NIL);
  wire tag_mis = {{(DATA_W-TYPE_W){1'b0}}, a_type} != b_data;

  logic [DATA_W:0] sum;
  assign sum = {a_data[DATA_W-1], a_data} + {b_data[DATA_W-1], b_data};
  wire ovf = sum[DATA_W] != sum[DATA_W-1];

  logic [3:0] code_n;
  always_comb begin
    code_n = 4'd0;
    if      (is_alu && chk_future && fut_a)             code_n = 4'd1;
    else if (is_alu && chk_future && fut_b)             code_n = 4'd2;
    else if (is_alu && chk_fixnum && (odd_a || odd_b))  code_n = 4'd3;
    else if (is_mem && chk_cons && !base_ok)            code_n = 4'd4;
    else if (is_tchk && tag_mis)                        code_n = 4'd5;
    else if (is_alu && chk_ovf && ovf)                  code_n = 4'd6;
    else if (is_store && chk_gen && (b_gen > a_gen))    code_n = 4'd7;
    else if (is_load && chk_transport && word_old)      code_n = 4'd8;
    else if (is_load && chk_empty && !word_full)        code_n = 4'd9;
  end

  wire clean = in_valid && code_n == 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      trap_valid <= 1'b0;
      trap_code  <= 4'd0;
      reg_we     <= 1'b0;
      fe_we      <= 1'b0;
      fe_val     <= 1'b0;
      old_we     <= 1'b0;
      old_val    <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      trap_valid <= in_valid && code_n != 4'd0;
      trap_code  <= in_valid ? code_n : 4'd0;
      reg_we     <= clean && (is_alu || is_load);
      fe_we      <= clean && is_load;
      fe_val     <= load_leave_full;
      old_we     <= clean && is_store;
      old_val    <= store_mark_old;
    end
  end
endmodule

// File: rtl/tag_trap_detect_chk.sv
module tag_trap_detect_chk #(
  parameter int GEN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       op_kind,
  input logic [GEN_W-1:0] a_gen,
  input logic [GEN_W-1:0] b_gen,
  input logic             chk_gen,
  input logic             out_valid,
  input logic             trap_valid,
  input logic [3:0]       trap_code,
  input logic             reg_we,
  input logic             fe_we,
  input logic             old_we
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !trap_valid && !reg_we && !fe_we && !old_we);
  // R2
  code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> trap_code == 4'd0);
  // R12
  trap_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !reg_we && !fe_we && !old_we);
  // R13
  tag_check_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd3) |=> !reg_we && !fe_we && !old_we);
  // R8
  gen_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd2 && chk_gen && b_gen > a_gen)
      |=> trap_valid && trap_code != 4'd0 && trap_code <= 4'd7);
endmodule

bind tag_trap_detect tag_trap_detect_chk #(.GEN_W(GEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
  .a_gen(a_gen), .b_gen(b_gen), .chk_gen(chk_gen),
  .out_valid(out_valid), .trap_valid(trap_valid), .trap_code(trap_code),
  .reg_we(reg_we), .fe_we(fe_we), .old_we(old_we)
);

// File: tb/test_tag_trap_detect.sv
module test_tag_trap_detect;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, TW = 5, GW = 3;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] op_kind;
  logic [DW-1:0] a_data, b_data;
  logic [TW-1:0] a_type, b_type;
  logic [GW-1:0] a_gen, b_gen;
  logic chk_future, chk_fixnum, chk_ovf, chk_cons, cons_nil_ok, chk_gen;
  logic chk_transport, chk_empty, load_leave_full, store_mark_old, word_full, word_old;
  logic out_valid, trap_valid, reg_we, fe_we, fe_val, old_we, old_val;
  logic [3:0] trap_code;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] code;
    logic rwe, fwe, fv, owe, ov;
    string tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_trap_detect i_tag_trap_detect (.*);

  function automatic logic [3:0] model_code();
    logic [DW:0] s;
    s = {a_data[DW-1], a_data} + {b_data[DW-1], b_data};
    if (op_kind == 0 && chk_future && a_type == 1) return 1;
    if (op_kind == 0 && chk_future && b_type == 1) return 2;
    if (op_kind == 0 && chk_fixnum && (a_type > 1 || b_type > 1)) return 3;
    if ((op_kind == 1 || op_kind == 2) && chk_cons &&
        !(a_type == 2 || (cons_nil_ok && a_type == 3))) return 4;
    if (op_kind == 3 && DW'(a_type) != b_data) return 5;
    if (op_kind == 0 && chk_ovf && (s[DW] != s[DW-1])) return 6;
    if (op_kind == 2 && chk_gen && b_gen > a_gen) return 7;
    if (op_kind == 1 && chk_transport && word_old) return 8;
    if (op_kind == 1 && chk_empty && !word_full) return 9;
    return 0;
  endfunction

  task automatic clr();
    op_kind = 0; a_data = 5; b_data = 7; a_type = 0; b_type = 0; a_gen = 0; b_gen = 0;
    chk_future = 1; chk_fixnum = 1; chk_ovf = 1; chk_cons = 1; cons_nil_ok = 0;
    chk_gen = 1; chk_transport = 1; chk_empty = 1; load_leave_full = 0;
    store_mark_old = 0; word_full = 1; word_old = 0;
  endtask

  task automatic fire(input string tag);
    exp_t e;
    @(negedge clk);
    e.code = model_code();
    e.rwe = (e.code == 0) && (op_kind == 0 || op_kind == 1);
    e.fwe = (e.code == 0) && op_kind == 1;
    e.fv  = load_leave_full;
    e.owe = (e.code == 0) && op_kind == 2;
    e.ov  = store_mark_old;
    e.tag = tag;
    q.push_back(e);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        n_chk++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected result: actual out_valid=1 expected 0");
        end else begin
          e = q.pop_front();
          if (!trap_valid !== (e.code == 0) || trap_code !== e.code || reg_we !== e.rwe ||
              fe_we !== e.fwe || old_we !== e.owe ||
              (e.fwe && fe_val !== e.fv) || (e.owe && old_val !== e.ov)) begin
            n_fail++;
            $display("FAIL %s: actual code=%0d tv=%b rwe=%b fwe=%b fv=%b owe=%b ov=%b expected code=%0d rwe=%b fwe=%b fv=%b owe=%b ov=%b",
              e.tag, trap_code, trap_valid, reg_we, fe_we, fe_val, old_we, old_val,
              e.code, e.rwe, e.fwe, e.fv, e.owe, e.ov);
          end
        end
      end
    end
  end

  task automatic idle_chk();
    @(negedge clk);
    n_chk++;
    if (out_valid || trap_valid || reg_we || fe_we || old_we) begin
      n_fail++;
      $display("FAIL R2 idle: actual ov=%b tv=%b rwe=%b fwe=%b owe=%b expected all 0",
        out_valid, trap_valid, reg_we, fe_we, old_we);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    n_chk++;
    // R1 reset state
    if (out_valid || trap_valid || trap_code != 0 || reg_we || fe_we || fe_val || old_we || old_val) begin
      n_fail++;
      $display("FAIL R1: actual ov=%b tv=%b code=%0d expected zeros", out_valid, trap_valid, trap_code);
    end
    rst_n = 1'b1;
    idle_chk();
    // R11 clean ALU
    clr(); fire("R11 alu clean");
    // R3
    clr(); a_type = 1; b_type = 1; fire("R3 both future -> first");
    clr(); b_type = 1; fire("R3 second future");
    // R4
    clr(); a_type = 7; fire("R4 odd type");
    clr(); a_type = 1; b_type = 9; fire("R4 future beats odd");
    clr(); a_type = 1; chk_future = 0; fire("R4 future is not odd");
    // R7
    clr(); a_data = 32'h7fffffff; b_data = 1; fire("R7 overflow");
    clr(); a_data = 32'h7fffffff; b_data = 1; chk_ovf = 0; fire("R7 disabled");
    clr(); a_data = 32'hffffffff; b_data = 1; fire("R7 no overflow");
    // R6 and R13
    clr(); op_kind = 3; a_type = 4; b_data = 4; fire("R6 R13 tags equal");
    clr(); op_kind = 3; a_type = 4; b_data = 5; fire("R6 tags differ");
    // R5
    clr(); op_kind = 1; a_type = 3; fire("R5 nil refused");
    clr(); op_kind = 1; a_type = 3; cons_nil_ok = 1; load_leave_full = 1; fire("R5 R11 nil accepted");
    clr(); op_kind = 2; a_type = 5; b_gen = 6; fire("R5 beats generation");
    // R8
    clr(); op_kind = 2; a_type = 2; a_gen = 3; b_gen = 5; fire("R8 gen inversion");
    clr(); op_kind = 2; a_type = 2; a_gen = 3; b_gen = 3; store_mark_old = 1; fire("R8 R11 equal gen stores");
    clr(); op_kind = 2; a_type = 2; a_gen = 4; b_gen = 1; store_mark_old = 0; fire("R11 store new");
    // R9 R10
    clr(); op_kind = 1; a_type = 2; word_old = 1; word_full = 0; fire("R9 R10 transport beats empty");
    clr(); op_kind = 1; a_type = 2; word_full = 0; fire("R10 empty");
    clr(); op_kind = 1; a_type = 2; word_full = 0; chk_empty = 0; load_leave_full = 0; fire("R10 R11 empty disabled");
    clr(); op_kind = 1; a_type = 2; word_old = 1; chk_transport = 0; load_leave_full = 1; fire("R9 R12 transport disabled");
    idle_chk();
    repeat (2) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule